// File: doc/BRIEF.md
# Multi-Banked Shared Memory Crossbar

This block is the front end of a cluster's shared scratch memory. A set of single-port SRAM banks sits behind it, and a larger set of bus masters sits in front of it. The masters can be compute cores, a control core, packet engines or a debug port. Every master has its own request path to every bank. Two masters interfere only when they address the same bank in the same cycle. Each bank then picks one requester with its own round-robin arbiter. The losing masters see ready held low and keep their request in place until it is accepted.

A static mode input selects how a byte address is split into bank and row. In interleaved mode, consecutive words rotate through the banks, which spreads streaming traffic. In blocked mode, each bank owns one contiguous slice of the address space. Software can then place a task's data in a bank that no other master touches, which keeps its access time free of interference. Reads return data on a per-master response port. Writes carry byte strobes and return nothing.

Top module: `shmx_xbar`

## Requirements
- R1: With `map_blocked` = 0, the word address (the byte address with its two low bits dropped) selects the bank from its low 4 bits and the row from the bits above them. Interleaved word w is therefore bank w mod 16, row w div 16.
- R2: With `map_blocked` = 1, the top 4 bits of the word address select the bank and the low 6 bits select the row. Bank b therefore owns words 64·b to 64·b+63.
- R3: Masters that target different banks are all accepted in the same cycle. Up to 16 masters can be accepted at once, and `req_ready` is never high for a master whose `req_valid` is low.
- R4: A bank accepts at most one request per cycle. When several masters target one bank, exactly one of them sees `req_ready` high.
- R5: After a bank grants master g, its priority starts at master g+1 (wrapping from 19 to 0). Out of reset, the priority starts at master 0.
- R6: An accepted read raises `rsp_valid` for that master in the next cycle only, with the addressed word on `rsp_rdata`.
- R7: Bit i of the 4-bit strobe enables byte lane i (data bits 8i+7..8i). Byte lanes whose strobe is 0 keep their stored value.
- R8: An accepted write produces no `rsp_valid` pulse.
- R9: While `rst_n` is low and after its release, `rsp_valid` is all zero until a read is accepted, and each bank's priority starts at master 0.
- R10: A master that holds a request waits no more than 19 cycles before it is accepted, even when all 20 masters target the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_blocked | input | 1 | 0 selects the interleaved map, 1 selects the blocked map |
| req_valid | input | 20 | Request valid, one bit per master |
| req_ready | output | 20 | Request accepted this cycle, one bit per master |
| req_addr | input | 240 | Byte address, 12 bits per master (master m at bits 12m+11..12m) |
| req_we | input | 20 | 1 = write, 0 = read, one bit per master |
| req_be | input | 80 | Byte strobes, 4 bits per master |
| req_wdata | input | 640 | Write data, 32 bits per master |
| rsp_valid | output | 20 | Read data valid, one bit per master |
| rsp_rdata | output | 640 | Read data, 32 bits per master |

## Verification
`req_ready` is combinational from the requests and the bank priority pointers. The bench therefore samples it 1 ns after the falling edge at which it drives its inputs, before the next rising edge. At that edge the request is accepted, the bank is written or read, and the pointer moves on. Read data and `rsp_valid` are registered once, so the bench samples them just after the following falling edge. One cycle later it checks that `rsp_valid` has dropped again. Round-robin order and waiting time are counted in whole cycles while the requesters keep their requests held.

// File: rtl/shmx_pkg.sv
`timescale 1ns/1ps
package shmx_pkg;
  typedef enum logic {
    MAP_INTERLEAVE = 1'b0,
    MAP_BLOCKED    = 1'b1
  } map_mode_e;
endpackage

// File: rtl/shmx_rr_arb.sv
`timescale 1ns/1ps
module shmx_rr_arb #(
  parameter int N = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 gnt_any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q;

  // first requester at or after the pointer, wrapping
  always_comb begin
    int unsigned idx;
    idx     = 0;
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!gnt_any && req[idx]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(idx);
      end
    end
    gnt = gnt_any ? ({{(N-1){1'b0}}, 1'b1} << gnt_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (gnt_any) begin
      ptr_q <= (int'(gnt_idx) == N-1) ? '0 : gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/shmx_bank.sv
`timescale 1ns/1ps
module shmx_bank #(
  parameter int WORDS  = 64,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic                     we,
  input  logic [DATA_W/8-1:0]      be,
  input  logic [$clog2(WORDS)-1:0] row,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int j = 0; j < LANES; j++) begin
          if (be[j]) mem[row][j*8 +: 8] <= wdata[j*8 +: 8];
        end
      end else begin
        rdata <= mem[row];
      end
    end
  end
endmodule

// File: rtl/shmx_xbar.sv
`timescale 1ns/1ps
module shmx_xbar
  import shmx_pkg::*;
#(
  parameter int NUM_MASTERS = 20,
  parameter int NUM_BANKS   = 16,
  parameter int BANK_WORDS  = 64,
  parameter int DATA_W      = 32,
  localparam int BE_W      = DATA_W / 8,
  localparam int BYTE_BITS = $clog2(BE_W),
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int ROW_BITS  = $clog2(BANK_WORDS),
  localparam int ADDR_W    = BYTE_BITS + BANK_BITS + ROW_BITS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          map_blocked,
  input  logic [NUM_MASTERS-1:0]        req_valid,
  output logic [NUM_MASTERS-1:0]        req_ready,
  input  logic [NUM_MASTERS*ADDR_W-1:0] req_addr,
  input  logic [NUM_MASTERS-1:0]        req_we,
  input  logic [NUM_MASTERS*BE_W-1:0]   req_be,
  input  logic [NUM_MASTERS*DATA_W-1:0] req_wdata,
  output logic [NUM_MASTERS-1:0]        rsp_valid,
  output logic [NUM_MASTERS*DATA_W-1:0] rsp_rdata
);
  localparam int WORD_W = BANK_BITS + ROW_BITS;
  localparam int MID_W  = $clog2(NUM_MASTERS);

  function automatic logic [BANK_BITS-1:0] bank_field(input logic [ADDR_W-1:0] a,
                                                      input map_mode_e md);
    logic [WORD_W-1:0] w;
    w = a[ADDR_W-1:BYTE_BITS];
    return (md == MAP_BLOCKED) ? w[WORD_W-1 -: BANK_BITS] : w[BANK_BITS-1:0];
  endfunction

  function automatic logic [ROW_BITS-1:0] row_field(input logic [ADDR_W-1:0] a,
                                                    input map_mode_e md);
    logic [WORD_W-1:0] w;
    w = a[ADDR_W-1:BYTE_BITS];
    return (md == MAP_BLOCKED) ? w[ROW_BITS-1:0] : w[WORD_W-1 -: ROW_BITS];
  endfunction

  map_mode_e mode;
  assign mode = map_blocked ? MAP_BLOCKED : MAP_INTERLEAVE;

  logic [NUM_MASTERS-1:0][ADDR_W-1:0] addr_m;
  logic [NUM_MASTERS-1:0][BE_W-1:0]   be_m;
  logic [NUM_MASTERS-1:0][DATA_W-1:0] wdata_m;
  assign addr_m  = req_addr;
  assign be_m    = req_be;
  assign wdata_m = req_wdata;

  logic [NUM_MASTERS-1:0][BANK_BITS-1:0] tgt_bank;
  logic [NUM_MASTERS-1:0][ROW_BITS-1:0]  tgt_row;

  always_comb begin
    for (int m = 0; m < NUM_MASTERS; m++) begin
      tgt_bank[m] = bank_field(addr_m[m], mode);
      tgt_row[m]  = row_field(addr_m[m], mode);
    end
  end

  // per-bank request, grant and data wires (brought out for the checker)
  logic [NUM_BANKS-1:0][NUM_MASTERS-1:0] bank_req;
  logic [NUM_BANKS-1:0][NUM_MASTERS-1:0] bank_gnt;
  logic [NUM_BANKS-1:0][MID_W-1:0]       bank_gidx;
  logic [NUM_BANKS-1:0]                  bank_fire;
  logic [NUM_BANKS-1:0][DATA_W-1:0]      bank_rdata;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int m = 0; m < NUM_MASTERS; m++) begin
        bank_req[b][m] = req_valid[m] && (tgt_bank[m] == BANK_BITS'(b));
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    shmx_rr_arb #(.N(NUM_MASTERS)) arb_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (bank_req[b]),
      .gnt     (bank_gnt[b]),
      .gnt_idx (bank_gidx[b]),
      .gnt_any (bank_fire[b])
    );
    shmx_bank #(.WORDS(BANK_WORDS), .DATA_W(DATA_W)) mem_i (
      .clk   (clk),
      .en    (bank_fire[b]),
      .we    (req_we[bank_gidx[b]]),
      .be    (be_m[bank_gidx[b]]),
      .row   (tgt_row[bank_gidx[b]]),
      .wdata (wdata_m[bank_gidx[b]]),
      .rdata (bank_rdata[b])
    );
  end

  always_comb begin
    req_ready = '0;
    for (int b = 0; b < NUM_BANKS; b++) req_ready = req_ready | bank_gnt[b];
  end

  logic [NUM_MASTERS-1:0] accept_rd;
  assign accept_rd = req_valid & req_ready & ~req_we;

  logic [NUM_MASTERS-1:0]                rsp_valid_q;
  logic [NUM_MASTERS-1:0][BANK_BITS-1:0] rsp_bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= '0;
      rsp_bank_q  <= '0;
    end else begin
      rsp_valid_q <= accept_rd;
      for (int m = 0; m < NUM_MASTERS; m++) begin
        if (accept_rd[m]) rsp_bank_q[m] <= tgt_bank[m];
      end
    end
  end

  logic [NUM_MASTERS-1:0][DATA_W-1:0] rdata_m;
  always_comb begin
    for (int m = 0; m < NUM_MASTERS; m++) rdata_m[m] = bank_rdata[rsp_bank_q[m]];
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rdata_m;
endmodule

// File: rtl/shmx_xbar_chk.sv
`timescale 1ns/1ps
module shmx_xbar_chk #(
  parameter int NUM_MASTERS = 20,
  parameter int NUM_BANKS   = 16
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic [NUM_MASTERS-1:0]               req_valid,
  input logic [NUM_MASTERS-1:0]               req_ready,
  input logic [NUM_MASTERS-1:0]               req_we,
  input logic [NUM_MASTERS-1:0]               rsp_valid,
  input logic [NUM_BANKS-1:0][NUM_MASTERS-1:0] bank_gnt
);
  localparam int CW = $clog2(NUM_MASTERS + 1) + 1;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_one
    assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_gnt[b]));
  end

  assert_ready_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  assert_ready_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_ready) <= NUM_BANKS);

  // R6 and R8: response pulses exactly follow accepted reads
  assert_read_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rsp_valid == $past(req_valid & req_ready & ~req_we));

  logic [NUM_MASTERS-1:0][CW-1:0] wait_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else begin
      for (int m = 0; m < NUM_MASTERS; m++) begin
        if (req_valid[m] && !req_ready[m]) begin
          if (wait_cnt[m] != '1) wait_cnt[m] <= wait_cnt[m] + 1'b1;
        end else begin
          wait_cnt[m] <= '0;
        end
      end
    end
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_wait
    assert_wait_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wait_cnt[m]) < NUM_MASTERS);
  end
endmodule

bind shmx_xbar shmx_xbar_chk #(
  .NUM_MASTERS (NUM_MASTERS),
  .NUM_BANKS   (NUM_BANKS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_we    (req_we),
  .rsp_valid (rsp_valid),
  .bank_gnt  (bank_gnt)
);

// File: tb/shmx_xbar_tb.sv
`timescale 1ns/1ps
module shmx_xbar_tb_top;
  localparam int M  = 20;
  localparam int NB = 16;
  localparam int RW = 64;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk = 1'b0;
  always #10 clk = ~clk;

  logic [M-1:0]    v  = '0;
  logic [M-1:0]    we = '0;
  logic [AW-1:0]   a  [M];
  logic [BW-1:0]   be [M];
  logic [DW-1:0]   wd [M];
  logic [M*AW-1:0] f_addr;
  logic [M*BW-1:0] f_be;
  logic [M*DW-1:0] f_wd;
  logic [M-1:0]    rdy, rv;
  logic [M*DW-1:0] rd;

  always_comb begin
    for (int m = 0; m < M; m++) begin
      f_addr[m*AW +: AW] = a[m];
      f_be[m*BW +: BW]   = be[m];
      f_wd[m*DW +: DW]   = wd[m];
    end
  end

  shmx_xbar dut_i (
    .clk(clk), .rst_n(rst_n), .map_blocked(blk),
    .req_valid(v), .req_ready(rdy), .req_addr(f_addr), .req_we(we),
    .req_be(f_be), .req_wdata(f_wd), .rsp_valid(rv), .rsp_rdata(rd)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [DW-1:0] ref_mem [NB*RW];

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // flat bank*RW+row index of a byte address under a given map
  function automatic int ref_idx(input logic [AW-1:0] ad, input bit blocked);
    int w;
    w = int'(ad) / 4;
    if (blocked) return w;
    return (w % NB) * RW + (w / NB);
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [BW-1:0] s);
    logic [DW-1:0] r;
    for (int j = 0; j < BW; j++) r[j*8 +: 8] = s[j] ? nw[j*8 +: 8] : old[j*8 +: 8];
    return r;
  endfunction

  // single access; called at a falling edge, returns at a falling edge + 1ns
  task automatic sacc(input int m, input logic [AW-1:0] ad, input bit w,
                      input logic [BW-1:0] s, input logic [DW-1:0] d,
                      output bit got_rv, output logic [DW-1:0] got_rd);
    v[m] = 1'b1; we[m] = w; a[m] = ad; be[m] = s; wd[m] = d;
    #1;
    while (!rdy[m]) begin @(negedge clk); #1; end
    if (w) ref_mem[ref_idx(ad, blk)] = merge(ref_mem[ref_idx(ad, blk)], d, s);
    @(posedge clk); @(negedge clk);
    v[m] = 1'b0;
    #1;
    got_rv = rv[m];
    got_rd = rd[m*DW +: DW];
  endtask

  task automatic t_reset();
    chk("R9", "rsp_valid in reset", 64'(rv), 64'd0);
    chk("R9", "ready in reset", 64'(rdy), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R9", "rsp_valid after reset", 64'(rv), 64'd0);
    @(negedge clk);
  endtask

  task automatic t_map();
    bit g; logic [DW-1:0] d;
    blk = 1'b0;
    sacc(0, 12'h004, 1'b1, 4'hF, 32'hA1A1_0001, g, d);
    chk("R8", "no response to write", 64'(g), 64'd0);
    blk = 1'b1;
    sacc(1, 12'h100, 1'b0, 4'hF, '0, g, d);
    chk("R1", "interleaved word1 seen as blocked bank1 row0 valid", 64'(g), 64'd1);
    chk("R1", "interleaved word1 seen as blocked bank1 row0 data", 64'(d), 64'hA1A1_0001);
    sacc(2, 12'h3C8, 1'b1, 4'hF, 32'h0B0C_0303, g, d);
    blk = 1'b0;
    sacc(3, 12'hC8C, 1'b0, 4'hF, '0, g, d);
    chk("R2", "blocked bank3 row50 seen interleaved", 64'(d), 64'h0B0C_0303);
    chk("R2", "model agrees", 64'(d), 64'(ref_mem[ref_idx(12'hC8C, 1'b0)]));
    @(negedge clk);
  endtask

  task automatic t_strobe();
    bit g; logic [DW-1:0] d;
    sacc(4, 12'h040, 1'b1, 4'hF, 32'h1122_3344, g, d);
    sacc(4, 12'h040, 1'b1, 4'h5, 32'hAABB_CCDD, g, d);
    chk("R8", "strobed write no response", 64'(g), 64'd0);
    sacc(5, 12'h040, 1'b0, 4'h0, '0, g, d);
    chk("R7", "lanes 0 and 2 replaced", 64'(d), 64'h11BB_33DD);
    sacc(5, 12'h040, 1'b1, 4'h8, 32'hEE00_0000, g, d);
    sacc(6, 12'h040, 1'b0, 4'h0, '0, g, d);
    chk("R7", "lane 3 only", 64'(d), 64'hEEBB_33DD);
    @(negedge clk); #1;
    chk("R6", "response lasts one cycle", 64'(rv), 64'd0);
    @(negedge clk);
  endtask

  task automatic t_rr();
    logic [M-1:0] exp_seq [4];
    exp_seq[0] = M'(1) << 3;
    exp_seq[1] = M'(1) << 7;
    exp_seq[2] = M'(1) << 12;
    exp_seq[3] = M'(1) << 3;
    blk = 1'b0;
    a[3] = 12'h014; a[7] = 12'h054; a[12] = 12'h094;
    for (int i = 0; i < M; i++) begin be[i] = 4'hF; wd[i] = 32'h0505_0000 + i; end
    we[3] = 1'b1; we[7] = 1'b1; we[12] = 1'b1;
    v[3] = 1'b1; v[7] = 1'b1; v[12] = 1'b1;
    for (int c = 0; c < 4; c++) begin
      #1;
      chk("R5", $sformatf("grant order step %0d", c), 64'(rdy), 64'(exp_seq[c]));
      for (int i = 0; i < M; i++)
        if (rdy[i]) ref_mem[ref_idx(a[i], 1'b0)] = wd[i];
      @(negedge clk);
    end
    v = '0; we = '0;
    @(negedge clk);
  endtask

  task automatic t_parallel();
    blk = 1'b0;
    for (int m = 0; m < NB; m++) begin
      a[m] = AW'((m + 2*NB) * 4); be[m] = 4'hF; wd[m] = (32'h0101_0101 * m) ^ 32'h5A;
      we[m] = 1'b1; v[m] = 1'b1;
    end
    #1;
    chk("R3", "16 writes to distinct banks accepted together", 64'(rdy), 64'h0FFFF);
    @(negedge clk);
    for (int m = 0; m < NB; m++) we[m] = 1'b0;
    #1;
    chk("R3", "16 reads to distinct banks accepted together", 64'(rdy), 64'h0FFFF);
    @(negedge clk);
    v = '0;
    #1;
    chk("R6", "all 16 responses next cycle", 64'(rv), 64'h0FFFF);
    for (int m = 0; m < NB; m++)
      chk("R6", $sformatf("read data master %0d", m), 64'(rd[m*DW +: DW]),
          64'((32'h0101_0101 * m) ^ 32'h5A));
    @(negedge clk); #1;
    chk("R6", "responses gone one cycle later", 64'(rv), 64'd0);
    @(negedge clk);
  endtask

  task automatic t_conflict();
    blk = 1'b0;
    for (int m = 16; m < 20; m++) begin
      a[m] = AW'((2 + NB*(m-16)) * 4); we[m] = 1'b0; v[m] = 1'b1;
    end
    #1;
    chk("R4", "one of four same-bank requests ready", 64'($countones(rdy)), 64'd1);
    chk("R4", "ready only among requesters", 64'(rdy & ~v), 64'd0);
    v = '0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_fair();
    int acc_cyc [M];
    int cnt [M];
    blk = 1'b0;
    for (int m = 0; m < M; m++) begin
      a[m] = AW'((9 + NB*m) * 4); we[m] = 1'b0; v[m] = 1'b1; acc_cyc[m] = -1; cnt[m] = 0;
    end
    for (int c = 0; c < M + 4; c++) begin
      #1;
      if (v != '0)
        chk("R4", $sformatf("single grant on hot bank cycle %0d", c),
            64'($countones(rdy)), 64'd1);
      for (int m = 0; m < M; m++)
        if (rdy[m]) begin acc_cyc[m] = c; cnt[m]++; end
      @(negedge clk);
      for (int m = 0; m < M; m++) if (acc_cyc[m] >= 0) v[m] = 1'b0;
    end
    for (int m = 0; m < M; m++) begin
      chk("R10", $sformatf("master %0d served once", m), 64'(cnt[m]), 64'd1);
      chk("R10", $sformatf("master %0d wait within bound", m),
          64'(acc_cyc[m] >= 0 && acc_cyc[m] < M), 64'd1);
    end
    v = '0;
    @(negedge clk);
  endtask

  initial begin
    for (int m = 0; m < M; m++) begin a[m] = '0; be[m] = '0; wd[m] = '0; end
    for (int i = 0; i < NB*RW; i++) ref_mem[i] = 'x;
    repeat (3) @(negedge clk);
    t_reset();
    t_map();
    t_strobe();
    t_rr();
    t_parallel();
    t_conflict();
    t_fair();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule